// File: doc/BRIEF.md
# Crosspoint Route Configuration Decoder

This block is the control side of an eight-source, six-sink video crosspoint. It watches a two-wire serial bus (I2C, write direction only), oversampling SCL and SDA with its own system clock. A transaction opens with a START. The first byte must carry the device address, which a strap input selects. Each byte after it is a route command that names one sink and the source that sink should carry. The block keeps one source-select register per sink and drives these registers out as mux select lines. It also keeps a per-sink flag that shows the sink has been programmed at least once since reset.

Sinks and sources are not numbered in plain binary on the wire. Both the 5-bit sink code and the 3-bit source code are scrambled, and some sink codes are unused. One command touches exactly one sink, and several sinks may carry the same source. Each accepted byte is acknowledged by pulling SDA low during the ninth clock.

Top module: `xbar_route_cfg`

## Requirements
- R1: While reset is held and just after it, every `route_sel_o` field is 0, `route_cfg_o` is all zeros and `sda_pull_o` is 0.
- R2: The address byte (first byte after a START, bit 7 first) is accepted only when it equals 0x86 with `strap_i` low, or 0x06 with `strap_i` high. An accepted byte is acknowledged by `sda_pull_o` = 1 (SDA low) for the whole ninth SCL clock.
- R3: Any other address byte gets no acknowledge. Every byte that follows it is ignored until the next START.
- R4: Each following byte is a route command. Bits 7..3 are the sink code and bits 2..0 are the source code. Bits are taken on rising SCL, most significant first. Every command byte is acknowledged. A register changes only after all eight bits have arrived.
- R5: Sink codes map as 00101→sink 1, 00100→sink 2, 00011→sink 3, 00010→sink 4, 00001→sink 5, 00000→sink 6. For example, byte 0x25 routes source 6 to sink 2.
- R6: Source codes map as 011→1, 010→2, 000→3, 001→4, 100→5, 101→6, 111→7, 110→8. Sink n's select appears at `route_sel_o[3n-1:3n-3]` as the source number minus one.
- R7: A command changes only the named sink's select. Every other sink keeps its value. Several sinks may hold the same source.
- R8: A command whose sink code is any other value (00110, 00111, or any code with bit 4 or bit 3 set) is acknowledged but changes no output.
- R9: `route_cfg_o[n-1]` becomes 1 when sink n is first written. It stays 1 until reset.
- R10: Any number of command bytes may follow the address within one transaction. Each one is applied in order.
- R11: A repeated START restarts address matching. A START or STOP that arrives in the middle of a byte discards that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 1 | Address strap: 0 selects 0x86, 1 selects 0x06 |
| sda_pull_o | output | 1 | 1 = pull SDA low (acknowledge) |
| route_sel_o | output | 18 | Six 3-bit source selects, sink 1 in the low bits |
| route_cfg_o | output | 6 | Per-sink programmed flag |

## Verification
The bench builds the block with its default parameters: eight sources, six sinks and a two-stage input synchronizer. Every bus quarter-bit lasts ten system clocks. Because the command space is only 256 values, the bench sweeps all eight low sink codes against all eight source codes inside long multi-byte transactions, plus samples of codes with the high bits set. It compares the whole select and flag vectors against an arithmetic model after every byte. Address matching is exercised under both strap levels, together with aborted bytes and repeated STARTs.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_ACK,
    ST_SKIP
  } slv_state_t;
endpackage

// File: rtl/i2c_sampler.sv
module i2c_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic start_p,
  output logic stop_p,
  output logic rise_p,
  output logic fall_p
);
  logic [SYNC_STAGES-1:0] scl_chain, sda_chain;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_i};
      sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
      scl_q     <= scl_s;
      sda_q     <= sda_s;
    end
  end

  assign scl_s   = scl_chain[SYNC_STAGES-1];
  assign sda_s   = sda_chain[SYNC_STAGES-1];
  assign start_p = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_p  = scl_s & scl_q & ~sda_q & sda_s;
  assign rise_p  = scl_s & ~scl_q;
  assign fall_p  = ~scl_s & scl_q;
endmodule

// File: rtl/i2c_wr_slave.sv
module i2c_wr_slave
  import xbar_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ADDR_LO = 8'h86,
  parameter logic [BYTE_W-1:0] ADDR_HI = 8'h06
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic              rise_p,
  input  logic              fall_p,
  input  logic              sda_s,
  input  logic              strap_i,
  output logic              sda_pull,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_byte
);
  slv_state_t        st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] my_addr;
  logic              byte_done;

  assign my_addr   = strap_i ? ADDR_HI : ADDR_LO;
  assign byte_done = fall_p && (cnt == CNT_W'(BYTE_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      sda_pull <= 1'b0;
      wr_valid <= 1'b0;
      wr_byte  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (start_p) begin
        st       <= ST_ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else if (stop_p) begin
        st       <= ST_IDLE;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_CMD: begin
            if (rise_p) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (byte_done) begin
              cnt <= '0;
              if (st == ST_CMD) begin
                sda_pull <= 1'b1;
                wr_valid <= 1'b1;
                wr_byte  <= shreg;
                st       <= ST_ACK;
              end else if (shreg == my_addr) begin
                sda_pull <= 1'b1;
                st       <= ST_ACK;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          ST_ACK: begin
            if (fall_p) begin
              sda_pull <= 1'b0;
              st       <= ST_CMD;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/xbar_code_map.sv
module xbar_code_map #(
  parameter int OUT_W = 3,
  parameter int IN_W  = 3
) (
  input  logic [7:0]       cmd,
  output logic             out_hit,
  output logic [OUT_W-1:0] out_idx,
  output logic [IN_W-1:0]  in_idx
);
  always_comb begin
    out_hit = 1'b1;
    unique case (cmd[7:3])
      5'b00101: out_idx = OUT_W'(0);
      5'b00100: out_idx = OUT_W'(1);
      5'b00011: out_idx = OUT_W'(2);
      5'b00010: out_idx = OUT_W'(3);
      5'b00001: out_idx = OUT_W'(4);
      5'b00000: out_idx = OUT_W'(5);
      default: begin
        out_hit = 1'b0;
        out_idx = '0;
      end
    endcase
  end

  always_comb begin
    unique case (cmd[2:0])
      3'b011:  in_idx = IN_W'(0);
      3'b010:  in_idx = IN_W'(1);
      3'b000:  in_idx = IN_W'(2);
      3'b001:  in_idx = IN_W'(3);
      3'b100:  in_idx = IN_W'(4);
      3'b101:  in_idx = IN_W'(5);
      3'b111:  in_idx = IN_W'(6);
      default: in_idx = IN_W'(7);
    endcase
  end
endmodule

// File: rtl/xbar_route_cfg.sv
module xbar_route_cfg #(
  parameter int N_IN        = 8,
  parameter int N_OUT       = 6,
  parameter int SYNC_STAGES = 2,
  localparam int IN_W  = $clog2(N_IN),
  localparam int OUT_W = $clog2(N_OUT)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic                  strap_i,
  output logic                  sda_pull_o,
  output logic [N_OUT*IN_W-1:0] route_sel_o,
  output logic [N_OUT-1:0]      route_cfg_o
);
  logic       sda_s, start_p, stop_p, rise_p, fall_p;
  logic       wr_valid, out_hit;
  logic [7:0] wr_byte;
  logic [OUT_W-1:0] out_idx;
  logic [IN_W-1:0]  in_idx;

  i2c_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .start_p(start_p), .stop_p(stop_p), .rise_p(rise_p), .fall_p(fall_p)
  );

  i2c_wr_slave u_slv (
    .clk(clk), .rst(rst), .start_p(start_p), .stop_p(stop_p),
    .rise_p(rise_p), .fall_p(fall_p), .sda_s(sda_s), .strap_i(strap_i),
    .sda_pull(sda_pull_o), .wr_valid(wr_valid), .wr_byte(wr_byte)
  );

  xbar_code_map #(.OUT_W(OUT_W), .IN_W(IN_W)) u_map (
    .cmd(wr_byte), .out_hit(out_hit), .out_idx(out_idx), .in_idx(in_idx)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_sink
    always_ff @(posedge clk) begin
      if (rst) begin
        route_sel_o[k*IN_W +: IN_W] <= '0;
        route_cfg_o[k]              <= 1'b0;
      end else if (wr_valid && out_hit && out_idx == OUT_W'(k)) begin
        route_sel_o[k*IN_W +: IN_W] <= in_idx;
        route_cfg_o[k]              <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/xbar_route_chk.sv
module xbar_route_chk #(
  parameter int N_OUT = 6,
  parameter int IN_W  = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scl_i,
  input logic                  sda_pull_o,
  input logic [N_OUT*IN_W-1:0] route_sel_o,
  input logic [N_OUT-1:0]      route_cfg_o
);
  logic [N_OUT*IN_W-1:0] prev_sel;
  logic [N_OUT-1:0]      prev_cfg, chg;
  logic                  prev_pull;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sel  <= '0;
      prev_cfg  <= '0;
      prev_pull <= 1'b0;
    end else begin
      prev_sel  <= route_sel_o;
      prev_cfg  <= route_cfg_o;
      prev_pull <= sda_pull_o;
    end
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_chg
    assign chg[k] = route_sel_o[k*IN_W +: IN_W] != prev_sel[k*IN_W +: IN_W];
  end

  assert_cfg_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (route_cfg_o & prev_cfg) == prev_cfg);
  assert_one_sink_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(chg) <= 1);
  assert_cfg_on_write_R9: assert property (@(posedge clk) disable iff (rst)
    (chg & ~route_cfg_o) == '0);
  assert_pull_scl_low_R2: assert property (@(posedge clk) disable iff (rst)
    (sda_pull_o != prev_pull) |-> !scl_i);
  assert_update_after_byte_R4: assert property (@(posedge clk) disable iff (rst)
    (|chg) |-> !scl_i);
endmodule

bind xbar_route_cfg xbar_route_chk #(.N_OUT(N_OUT), .IN_W(IN_W)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .route_sel_o(route_sel_o), .route_cfg_o(route_cfg_o)
);

// File: tb/tb_xbar_route_cfg.sv
module tb_xbar_route_cfg;
  localparam int Q = 10;
  logic clk = 1'b0, rst = 1'b1;
  logic scl_drv = 1'b1, sda_drv = 1'b1, strap = 1'b0;
  logic sda_line, sda_pull_o;
  logic [17:0] route_sel_o;
  logic [5:0]  route_cfg_o;
  int checks = 0, errors = 0;
  logic [17:0] exp_sel = '0;
  logic [5:0]  exp_cfg = '0;

  always #4 clk = ~clk;
  assign sda_line = sda_drv & ~sda_pull_o;

  xbar_route_cfg dut (
    .clk(clk), .rst(rst), .scl_i(scl_drv), .sda_i(sda_line), .strap_i(strap),
    .sda_pull_o(sda_pull_o), .route_sel_o(route_sel_o), .route_cfg_o(route_cfg_o)
  );

  function automatic int sink_of(input logic [4:0] c);
    case (c)
      5'b00101: return 1;
      5'b00100: return 2;
      5'b00011: return 3;
      5'b00010: return 4;
      5'b00001: return 5;
      5'b00000: return 6;
      default:  return 0;
    endcase
  endfunction

  function automatic int src_of(input logic [2:0] c);
    case (c)
      3'b011: return 1;
      3'b010: return 2;
      3'b000: return 3;
      3'b001: return 4;
      3'b100: return 5;
      3'b101: return 6;
      3'b111: return 7;
      default: return 8;
    endcase
  endfunction

  task automatic apply(input logic [7:0] b);
    int s = sink_of(b[7:3]);
    if (s > 0) begin
      exp_sel[(s-1)*3 +: 3] = 3'(src_of(b[2:0]) - 1);
      exp_cfg[s-1] = 1'b1;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_routes(input string tag);
    chk(route_sel_o == exp_sel, {tag, " sel"}, 32'(route_sel_o), 32'(exp_sel));
    chk(route_cfg_o == exp_cfg, {tag, " cfg"}, 32'(route_cfg_o), 32'(exp_cfg));
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1; wq(); scl_drv = 1; wq(); sda_drv = 0; wq(); scl_drv = 0; wq();
  endtask

  task automatic bus_stop();
    sda_drv = 0; wq(); scl_drv = 1; wq(); sda_drv = 1; wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_drv = b[i]; wq(); scl_drv = 1; wq(); wq(); scl_drv = 0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_drv = 1; wq(); scl_drv = 1; wq();
    ack = !sda_line;
    wq(); scl_drv = 0; wq();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ack;
    repeat (5) @(negedge clk);
    // R1: reset values
    chk(sda_pull_o == 0, "R1 pull in reset", 32'(sda_pull_o), 0);
    chk_routes("R1 in reset");
    rst = 0;
    repeat (5) @(negedge clk);
    chk_routes("R1 after reset");

    // R3: wrong address, then command ignored
    bus_start();
    send_byte(8'h06, ack);
    chk(ack == 0, "R3 wrong addr nack", 32'(ack), 0);
    send_byte(8'h25, ack);
    chk(ack == 0, "R3 byte after wrong addr", 32'(ack), 0);
    bus_stop();
    chk_routes("R3 no change");

    // R2 R5 R6: 0x25 routes source 6 to sink 2
    bus_start();
    send_byte(8'h86, ack);
    chk(ack == 1, "R2 addr ack strap low", 32'(ack), 1);
    send_byte(8'h25, ack);
    apply(8'h25);
    chk(ack == 1, "R4 cmd ack", 32'(ack), 1);
    bus_stop();
    chk(route_sel_o[5:3] == 3'd5, "R5 R6 0x25 sink2 src6", 32'(route_sel_o[5:3]), 5);
    chk_routes("R9 cfg after 0x25");

    // R5 R6 R7 R8 R10: sweep low sink codes x all source codes
    for (int oc = 0; oc < 8; oc++) begin
      bus_start();
      send_byte(8'h86, ack);
      chk(ack == 1, "R2 addr ack sweep", 32'(ack), 1);
      for (int ic = 0; ic < 8; ic++) begin
        send_byte(8'((oc << 3) | ic), ack);
        apply(8'((oc << 3) | ic));
        chk(ack == 1, "R8 R4 ack every cmd", 32'(ack), 1);
        chk_routes("R5 R6 R7 R10 sweep");
      end
      bus_stop();
    end

    // R8: high sink codes ignored
    bus_start();
    send_byte(8'h86, ack);
    for (int j = 0; j < 6; j++) begin
      logic [7:0] b = 8'(8'h40 + j * 8'h25);
      send_byte(b, ack);
      apply(b);
      chk(ack == 1, "R8 high code ack", 32'(ack), 1);
      chk_routes("R8 high code no change");
    end
    bus_stop();

    // R7: several sinks share source 1
    bus_start();
    send_byte(8'h86, ack);
    for (int s = 0; s < 6; s++) begin
      send_byte(8'((s << 3) | 3), ack);
      apply(8'((s << 3) | 3));
    end
    bus_stop();
    chk(route_sel_o == 18'd0, "R7 shared source", 32'(route_sel_o), 0);
    chk_routes("R7 shared");

    // R11: partial byte aborted by STOP
    bus_start();
    send_byte(8'h86, ack);
    send_bits(8'h2E, 5);
    bus_stop();
    chk_routes("R11 partial byte stop");

    // R11: repeated START with wrong address, then with right one
    bus_start();
    send_byte(8'h86, ack);
    send_bits(8'h1C, 3);
    bus_start();
    send_byte(8'h84, ack);
    chk(ack == 0, "R11 restart wrong addr", 32'(ack), 0);
    send_byte(8'h1C, ack);
    chk_routes("R11 ignored after restart");
    bus_start();
    send_byte(8'h86, ack);
    chk(ack == 1, "R11 restart good addr", 32'(ack), 1);
    send_byte(8'h1E, ack);
    apply(8'h1E);
    bus_stop();
    chk_routes("R11 applied after restart");

    // R2: strap high
    strap = 1;
    bus_start();
    send_byte(8'h86, ack);
    chk(ack == 0, "R2 strap high rejects 86", 32'(ack), 0);
    bus_stop();
    bus_start();
    send_byte(8'h06, ack);
    chk(ack == 1, "R2 strap high accepts 06", 32'(ack), 1);
    send_byte(8'h2F, ack);
    apply(8'h2F);
    bus_stop();
    chk_routes("R2 strap high write");

    // R1 R9: reset clears everything
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    exp_sel = '0; exp_cfg = '0;
    @(negedge clk);
    chk_routes("R1 R9 cleared by reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule